// File: doc/BRIEF.md
# Dual-Issue Four-Stage Add Pipeline

This block is a two-lane, in-order pipelined datapath that executes one kind of instruction: the three-register integer add. Each clock it fetches a pair of 32-bit instruction words from a small internal instruction store and sends each word down its own lane. Every lane has four stages: fetch, decode with operand read, execute and writeback. Both lanes share one register file with four read ports and two write ports. A fully loaded pipeline therefore retires two instructions per clock.

The pipeline has no forwarding paths and no interlocks. An operand is always taken from the register file during decode. Software must space dependent instructions far enough apart to see the value it needs. Any word that is not an add passes through the pipeline without effect. A load port fills the instruction store and the register file while reset is held. A debug read port shows any register, so that results can be inspected once the pipeline has drained.

Top module: `dual_add_pipe`

## Requirements
- R1: While `rst_n` is low, the pipeline writes nothing to the register file, and all stages hold no valid instruction. The first fetch after reset release uses byte address 0.
- R2: Each clock the PC advances by 8 bytes. Lane 0 takes instruction word PC/4 and lane 1 takes word PC/4+1. Both indices wrap at the end of the instruction store.
- R3: An add word has bits [31:26] = 0 and bits [5:0] = 0x20, with rs in [25:21], rt in [20:16] and rd in [15:11]. It writes rd = (rs + rt) mod 2^32.
- R4: Any word that does not match the add encoding of R3 changes no register. This includes the all-ones word and a word with function code 0x21.
- R5: A pair fetched on clock edge k is written to the register file on edge k+3. The pair fetched on the first edge after reset release is written on the fourth edge.
- R6: Results are not forwarded. Decode reads the register file as it stands during that cycle. A write that occurs at the end of the same cycle is not seen. A consumer sees a producer's result only when it is fetched three or more pairs after the producer.
- R7: The two lanes of a pair read their operands independently. Lane 1 never sees the result of lane 0 from the same pair.
- R8: If both lanes of a pair name the same rd, the register keeps the lane 1 result.
- R9: Register 0 always reads as zero, and writes to it are dropped.
- R10: With `imem_ld_en` high, `imem_ld_data` is written to instruction word `imem_ld_addr` on the clock edge. With `rf_ld_en` high, `rf_ld_data` is written to register `rf_ld_addr` on the clock edge. `dbg_data` shows register `dbg_addr` combinationally.
- R11: Start from r1=22, r2=33, r3=44 and r4=55. Run two adds targeting r0, then add r1,r1,r1; add r2,r2,r2; add r3,r3,r3; add r4,r4,r4. The registers end at 44, 66, 88 and 110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| imem_ld_en | input | 1 | Write strobe for the instruction store |
| imem_ld_addr | input | 6 | Word index written in the instruction store |
| imem_ld_data | input | 32 | Instruction word to store |
| rf_ld_en | input | 1 | Write strobe for the register file preload |
| rf_ld_addr | input | 5 | Register index to preload |
| rf_ld_data | input | 32 | Preload value |
| dbg_addr | input | 5 | Register index to observe |
| dbg_data | output | 32 | Current value of register `dbg_addr` |

## Verification
The assertions assume three things about the inputs. Loading happens only while reset is held. The instruction store depth is a power of two, so PC wrap matches the index wrap. A load never falls on the same edge as a pipeline writeback to the same register. Every stimulus sequence asserts reset, loads the instruction store and the register file, and only then releases reset, so all three conditions hold. The test programs place dependent instructions at distances of one, two and three pairs on purpose. This exposes the stale-read window. They also include same-pair write conflicts, non-add words and wrap-around, and every outcome is compared with a behavioural model on every clock.

// File: rtl/dap_pkg.sv
package dap_pkg;
  localparam int XLEN = 32;
  localparam int RA_W = 5;
  localparam int NREG = 1 << RA_W;

  localparam logic [5:0] OP_REGFMT = 6'd0;
  localparam logic [5:0] FN_SUM    = 6'h20;

  typedef struct packed {
    logic [RA_W-1:0] rd;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
  } idex_t;

  typedef struct packed {
    logic [RA_W-1:0] rd;
    logic [XLEN-1:0] sum;
  } exwb_t;

  function automatic logic is_sum_op(input logic [XLEN-1:0] w);
    return (w[31:26] == OP_REGFMT) && (w[5:0] == FN_SUM);
  endfunction
endpackage

// File: rtl/dap_imem.sv
module dap_imem
  import dap_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LANES = 2,
  parameter int IA_W  = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       ld_en,
  input  logic [IA_W-1:0]            ld_addr,
  input  logic [XLEN-1:0]            ld_data,
  input  logic [LANES-1:0][IA_W-1:0] rd_idx,
  output logic [LANES-1:0][XLEN-1:0] rd_word
);
  logic [XLEN-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_en) store[ld_addr] <= ld_data;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign rd_word[g] = store[rd_idx[g]];
  end
endmodule

// File: rtl/dap_regfile.sv
module dap_regfile
  import dap_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [2*LANES-1:0][RA_W-1:0] rd_addr,
  output logic [2*LANES-1:0][XLEN-1:0] rd_data,
  input  logic [LANES-1:0]             wr_en,
  input  logic [LANES-1:0][RA_W-1:0]   wr_addr,
  input  logic [LANES-1:0][XLEN-1:0]   wr_data,
  input  logic                         ld_en,
  input  logic [RA_W-1:0]              ld_addr,
  input  logic [XLEN-1:0]              ld_data,
  input  logic [RA_W-1:0]              dbg_addr,
  output logic [XLEN-1:0]              dbg_data
);
  logic [XLEN-1:0] regs [NREG];

  // later lanes override earlier ones by statement order
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (wr_en[i] && (wr_addr[i] != '0)) regs[wr_addr[i]] <= wr_data[i];
    end
    if (ld_en && (ld_addr != '0)) regs[ld_addr] <= ld_data;
  end

  for (genvar g = 0; g < 2*LANES; g++) begin : g_rd
    assign rd_data[g] = (rd_addr[g] == '0) ? '0 : regs[rd_addr[g]];
  end

  assign dbg_data = (dbg_addr == '0) ? '0 : regs[dbg_addr];

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    logic later_hit;
    always_comb begin
      later_hit = ld_en;
      for (int j = i + 1; j < LANES; j++) begin
        if (wr_en[j] && (wr_addr[j] == wr_addr[i])) later_hit = 1'b1;
      end
    end
    // R8
    lane_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[i] && (wr_addr[i] != '0) && !later_hit)
      |=> regs[$past(wr_addr[i])] == $past(wr_data[i]));
  end
endmodule

// File: rtl/dap_lane.sv
module dap_lane
  import dap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] fetch_word,
  output logic [RA_W-1:0] rs_idx,
  output logic [RA_W-1:0] rt_idx,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic            wb_en,
  output logic [RA_W-1:0] wb_idx,
  output logic [XLEN-1:0] wb_val
);
  logic            if_vld_q;
  logic [XLEN-1:0] if_ir_q;
  logic            id_vld_q, id_vld_d;
  idex_t           idex_q, idex_d;
  logic            ex_vld_q, ex_vld_d;
  exwb_t           exwb_q, exwb_d;
  logic            dec_ok;

  // decode / operand read
  always_comb begin
    rs_idx     = if_ir_q[25:21];
    rt_idx     = if_ir_q[20:16];
    dec_ok     = is_sum_op(if_ir_q);
    id_vld_d   = if_vld_q & dec_ok;
    idex_d.rd  = if_ir_q[15:11];
    idex_d.opa = rs_val;
    idex_d.opb = rt_val;
  end

  // execute
  always_comb begin
    ex_vld_d   = id_vld_q;
    exwb_d.rd  = idex_q.rd;
    exwb_d.sum = idex_q.opa + idex_q.opb;
  end

  // valid bits: async reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      if_vld_q <= 1'b0;
      id_vld_q <= 1'b0;
      ex_vld_q <= 1'b0;
    end else begin
      if_vld_q <= 1'b1;
      id_vld_q <= id_vld_d;
      ex_vld_q <= ex_vld_d;
    end
  end

  // payload: no reset, enabled by the stage feeding it
  always_ff @(posedge clk) begin
    if_ir_q <= fetch_word;
    if (id_vld_d) idex_q <= idex_d;
    if (ex_vld_d) exwb_q <= exwb_d;
  end

  assign wb_en  = ex_vld_q;
  assign wb_idx = exwb_q.rd;
  assign wb_val = exwb_q.sum;

  // R5
  id_to_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_vld_q |=> wb_en);
  // R4
  wb_only_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> $past(if_vld_q && is_sum_op(if_ir_q), 2));
  // R3
  wb_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_val == XLEN'($past(rs_val, 2) + $past(rt_val, 2)));
endmodule

// File: rtl/dual_add_pipe.sv
module dual_add_pipe
  import dap_pkg::*;
#(
  parameter int LANES      = 2,
  parameter int IMEM_DEPTH = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          imem_ld_en,
  input  logic [$clog2(IMEM_DEPTH)-1:0] imem_ld_addr,
  input  logic [XLEN-1:0]               imem_ld_data,
  input  logic                          rf_ld_en,
  input  logic [RA_W-1:0]               rf_ld_addr,
  input  logic [XLEN-1:0]               rf_ld_data,
  input  logic [RA_W-1:0]               dbg_addr,
  output logic [XLEN-1:0]               dbg_data
);
  localparam int IA_W    = $clog2(IMEM_DEPTH);
  localparam int PC_W    = IA_W + 2;
  localparam int PC_STEP = 4 * LANES;

  logic [PC_W-1:0]                  pc_q, pc_d;
  logic [LANES-1:0][IA_W-1:0]       fetch_idx;
  logic [LANES-1:0][XLEN-1:0]       fetch_word;
  logic [2*LANES-1:0][RA_W-1:0]     rf_raddr;
  logic [2*LANES-1:0][XLEN-1:0]     rf_rdata;
  logic [LANES-1:0]                 wb_en;
  logic [LANES-1:0][RA_W-1:0]       wb_idx;
  logic [LANES-1:0][XLEN-1:0]       wb_val;

  always_comb begin
    pc_d = pc_q + PC_W'(PC_STEP);
    for (int g = 0; g < LANES; g++) begin
      fetch_idx[g] = pc_q[PC_W-1:2] + IA_W'(g);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  dap_imem #(.DEPTH(IMEM_DEPTH), .LANES(LANES), .IA_W(IA_W)) u_imem (
    .clk     (clk),
    .ld_en   (imem_ld_en),
    .ld_addr (imem_ld_addr),
    .ld_data (imem_ld_data),
    .rd_idx  (fetch_idx),
    .rd_word (fetch_word)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dap_lane u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .fetch_word (fetch_word[g]),
      .rs_idx     (rf_raddr[2*g]),
      .rt_idx     (rf_raddr[2*g+1]),
      .rs_val     (rf_rdata[2*g]),
      .rt_val     (rf_rdata[2*g+1]),
      .wb_en      (wb_en[g]),
      .wb_idx     (wb_idx[g]),
      .wb_val     (wb_val[g])
    );
  end

  dap_regfile #(.LANES(LANES)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_addr  (rf_raddr),
    .rd_data  (rf_rdata),
    .wr_en    (wb_en),
    .wr_addr  (wb_idx),
    .wr_data  (wb_val),
    .ld_en    (rf_ld_en),
    .ld_addr  (rf_ld_addr),
    .ld_data  (rf_ld_data),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
  );

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pc_q == PC_W'($past(pc_q) + PC_W'(PC_STEP)));
endmodule

// File: tb/tb_dual_add_pipe.sv
module tb_dual_add_pipe;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_ld_en = 1'b0;
  logic [5:0]  imem_ld_addr = '0;
  logic [31:0] imem_ld_data = '0;
  logic        rf_ld_en = 1'b0;
  logic [4:0]  rf_ld_addr = '0;
  logic [31:0] rf_ld_data = '0;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_data;

  always #2.5 clk = ~clk;

  dual_add_pipe dut (
    .clk(clk), .rst_n(rst_n),
    .imem_ld_en(imem_ld_en), .imem_ld_addr(imem_ld_addr), .imem_ld_data(imem_ld_data),
    .rf_ld_en(rf_ld_en), .rf_ld_addr(rf_ld_addr), .rf_ld_data(rf_ld_data),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] img [DEPTH];
  logic [31:0] rf_init [32];
  logic [31:0] mrf [32];
  logic [31:0] watch_log [64];
  int          due_q [$];
  int          rd_q [$];
  logic [31:0] val_q [$];

  function automatic logic [31:0] enc(input int rd, input int rs, input int rt);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic peek(input int r, output logic [31:0] v);
    dbg_addr = 5'(r);
    #0.5;
    v = dbg_data;
  endtask

  task automatic clear_img();
    for (int w = 0; w < DEPTH; w++) img[w] = '0;
  endtask

  task automatic run_prog(input int cycles, input int watch);
    logic [31:0] v;
    rst_n = 1'b0;
    @(negedge clk);
    for (int w = 0; w < DEPTH; w++) begin
      imem_ld_en = 1'b1; imem_ld_addr = 6'(w); imem_ld_data = img[w];
      @(negedge clk);
    end
    imem_ld_en = 1'b0;
    for (int r = 0; r < 32; r++) begin
      rf_ld_en = 1'b1; rf_ld_addr = 5'(r); rf_ld_data = rf_init[r];
      @(negedge clk);
    end
    rf_ld_en = 1'b0;
    for (int r = 0; r < 32; r++) mrf[r] = rf_init[r];
    mrf[0] = '0;
    due_q.delete(); rd_q.delete(); val_q.delete();
    // R1: held in reset with a program loaded, registers stay at preload (R10)
    repeat (4) @(negedge clk);
    for (int r = 1; r < 5; r++) begin
      peek(r, v);
      check($sformatf("R1/R10 reset hold r%0d", r), v, rf_init[r]);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int e = 1; e <= cycles; e++) begin
      int ra;
      @(posedge clk);
      #1;
      while (due_q.size() > 0 && due_q[0] == e) begin
        int rdv;
        rdv = rd_q.pop_front();
        mrf[rdv] = val_q.pop_front();
        void'(due_q.pop_front());
      end
      for (int l = 0; l < 2; l++) begin
        logic [31:0] w;
        w = img[(2*(e-1)+l) % DEPTH];
        if (w[31:26] == 6'd0 && w[5:0] == 6'h20 && w[15:11] != 5'd0) begin
          due_q.push_back(e + 3);
          rd_q.push_back(int'(w[15:11]));
          val_q.push_back(mrf[w[25:21]] + mrf[w[20:16]]);
        end
      end
      ra = (watch >= 0) ? watch : (e % 32);
      peek(ra, v);
      if (e < 64) watch_log[e] = v;
      check($sformatf("R6 model r%0d edge %0d", ra, e), v, mrf[ra]);
    end
  endtask

  initial begin
    logic [31:0] v;
    // program 1: reference sequence
    clear_img();
    for (int r = 0; r < 32; r++) rf_init[r] = '0;
    rf_init[1] = 22; rf_init[2] = 33; rf_init[3] = 44; rf_init[4] = 55;
    img[0] = enc(0, 0, 0); img[1] = enc(0, 0, 0);
    img[2] = enc(1, 1, 1); img[3] = enc(2, 2, 2);
    img[4] = enc(3, 3, 3); img[5] = enc(4, 4, 4);
    run_prog(16, 1);
    // R5: pair fetched on edge 2 lands on edge 5
    check("R5 r1 before edge 5", watch_log[4], 32'd22);
    check("R5 r1 after edge 5", watch_log[5], 32'd44);
    peek(1, v); check("R11 r1", v, 32'd44);
    peek(2, v); check("R11 r2", v, 32'd66);
    peek(3, v); check("R11 r3", v, 32'd88);
    peek(4, v); check("R11 r4", v, 32'd110);
    peek(0, v); check("R9 r0 after nop adds", v, 32'd0);

    // program 2: hazards, conflicts, non-add words, overflow
    clear_img();
    for (int r = 0; r < 32; r++) rf_init[r] = 32'(r * 1000 + 7);
    rf_init[31] = 32'h8000_0005;
    img[0]  = enc(5, 1, 2);   img[1]  = enc(5, 3, 4);
    img[2]  = enc(6, 5, 0);   img[3]  = enc(7, 1, 1);
    img[4]  = enc(8, 5, 0);   img[5]  = 32'hFFFF_FFFF;
    img[6]  = enc(9, 5, 0);   img[7]  = enc(10, 9, 1);
    img[8]  = enc(0, 1, 2);   img[9]  = enc(11, 0, 2);
    img[10] = enc(12, 31, 31);
    img[11] = {6'd0, 5'd1, 5'd2, 5'd13, 5'd0, 6'h21};
    run_prog(20, -1);
    peek(5, v);  check("R8 r5 lane1 wins", v, 32'd7014);
    peek(6, v);  check("R6 r6 stale one pair later", v, 32'd5007);
    peek(7, v);  check("R3 r7", v, 32'd2014);
    peek(8, v);  check("R6 r8 stale on write cycle", v, 32'd5007);
    peek(9, v);  check("R6 r9 sees result three pairs later", v, 32'd7014);
    peek(10, v); check("R7 r10 same-pair independence", v, 32'd10014);
    peek(0, v);  check("R9 r0 write dropped", v, 32'd0);
    peek(11, v); check("R9 r11 reads r0 as zero", v, 32'd2007);
    peek(12, v); check("R3 r12 wraps mod 2^32", v, 32'h0000_000A);
    peek(13, v); check("R4 r13 funct 0x21 ignored", v, 32'd13007);
    peek(2, v);  check("R4 r2 untouched by all-ones word", v, 32'd2007);

    // program 3: fetch wrap-around
    clear_img();
    img[0]  = enc(15, 15, 1);
    img[63] = enc(17, 17, 1);
    run_prog(40, -1);
    peek(15, v); check("R2 r15 word 0 fetched twice", v, 32'd17021);
    peek(17, v); check("R2 r17 last word lane 1", v, 32'd18014);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5ns);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule